// File: doc/BRIEF.md
# Two-Write Reset Sequencer

This block gives a remote controller a way to reset the local processor complex when the only thing that controller can issue is a memory write. The block watches a simple single-cycle write bus. It fires only when a correctly ordered pair of writes lands on two fixed addresses, and each write must carry an exact code. Any single stray write cannot reset the system. This preserves the legacy two-step reset-control handshake, in which a "select" write is followed by a "go" write that sets the trigger bit.

The first write, to the arm address, carries either code 0x02 (hard) or 0x00 (soft). Bit 1 of the code chooses the reset kind. The second write, to the fire address, must repeat the same code with bit 2 set: 0x06 for hard, 0x04 for soft. When the pair completes, the block holds the chosen reset lines for a parameterised number of clock cycles and then returns to idle. A hard reset drives the processor reset, the active-low bus reset and the legacy drive reset together. A soft reset drives only the processor INIT line. The soft path can be removed with a parameter.

The sequencer is cleared only by its own power-on reset input. The reset it generates therefore never disturbs its own state while a pulse is running.

Top module: `rstseq_top`

## Requirements
- R1: A write to address 0xFFFFFFF0 with data exactly 0x00000002 (hard) or 0x00000000 (soft) arms the sequencer. Arming by itself changes no output.
- R2: While armed, a write to address 0xFFFFFFF4 whose data equals the arming code with bit 2 set (0x00000006 after 0x02, 0x00000004 after 0x00) starts a reset pulse. The pulse is visible on the outputs in the cycle after that write.
- R3: A hard pulse drives cpu_rst=1, drv_rst=1 and bus_rst_n=0, with cpu_init=0.
- R4: A soft pulse drives cpu_init=1, with cpu_rst=0, drv_rst=0 and bus_rst_n=1.
- R5: While armed, any other write returns the sequencer to idle with no pulse. This covers a wrong address, wrong data, a repeated arming write, and a hard arming code followed by the soft fire code. A fire write that follows such a break does nothing.
- R6: A fire-address write that arrives without a preceding arming write produces no pulse. Reversing the order of the two writes does not fire.
- R7: The reset outputs stay asserted for exactly PULSE_CYCLES (default 16) consecutive cycles and are then released. Idle cycles between the two writes do not prevent the pulse.
- R8: Writes during a pulse are ignored. They do not change its kind or length, and they leave nothing armed after it.
- R9: While por_n is low, and right after it rises, the sequencer is idle with cpu_rst=0, drv_rst=0, cpu_init=0 and bus_rst_n=1. A por_n assertion during a pulse ends the pulse.
- R10: With SOFT_EN=0, the soft code pair never asserts cpu_init or any other reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the sequencer |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| cpu_rst | output | 1 | Processor reset, active high |
| bus_rst_n | output | 1 | Peripheral bus reset, active low |
| drv_rst | output | 1 | Legacy drive reset, active high |
| cpu_init | output | 1 | Processor INIT (soft reset), active high |

## Verification
The bench drives complete hard and soft pairs, both back to back and separated by idle cycles. These show that the pair fires regardless of spacing and that bit 1 alone selects which outputs move. A family of broken pairs exercises the break rule and shows that a near-miss never fires: wrong fire data, the mixed hard-then-soft codes, reversed order, a repeated arming write, and a fire write after a break. Writes issued during a pulse, plus a power-on reset in the middle of a pulse, separate "ignored" from "restarted" and "truncated". A second instance with the soft path removed shows that the soft pattern is inert there.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PULSE = 2'd2
  } seq_state_e;

  typedef enum logic {
    KIND_SOFT = 1'b0,
    KIND_HARD = 1'b1
  } rst_kind_e;

  // Data bit choosing the reset kind, and the bit that must rise to trigger.
  localparam int SEL_BIT  = 1;
  localparam int TRIG_BIT = 2;

  function automatic logic [7:0] arm_code(input rst_kind_e k);
    return (k == KIND_HARD) ? 8'(1 << SEL_BIT) : 8'h00;
  endfunction

  function automatic logic [7:0] fire_code(input rst_kind_e k);
    return arm_code(k) | 8'(1 << TRIG_BIT);
  endfunction

endpackage

// File: rtl/rstseq_decode.sv
module rstseq_decode
  import rstseq_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] ARM_ADDR  = 32'hFFFF_FFF0,
  parameter logic [31:0] FIRE_ADDR = 32'hFFFF_FFF4,
  parameter bit          SOFT_EN   = 1'b1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              arm_hit,
  output rst_kind_e         arm_kind,
  output logic              fire_hard,
  output logic              fire_soft
);

  localparam logic [DATA_W-1:0] ARM_HARD_D  = DATA_W'(arm_code(KIND_HARD));
  localparam logic [DATA_W-1:0] ARM_SOFT_D  = DATA_W'(arm_code(KIND_SOFT));
  localparam logic [DATA_W-1:0] FIRE_HARD_D = DATA_W'(fire_code(KIND_HARD));
  localparam logic [DATA_W-1:0] FIRE_SOFT_D = DATA_W'(fire_code(KIND_SOFT));

  logic at_arm, at_fire;
  logic soft_arm_ok, soft_fire_ok;

  assign at_arm  = wr_en && (wr_addr == ADDR_W'(ARM_ADDR));
  assign at_fire = wr_en && (wr_addr == ADDR_W'(FIRE_ADDR));

  generate
    if (SOFT_EN) begin : g_soft
      assign soft_arm_ok  = (wr_data == ARM_SOFT_D);
      assign soft_fire_ok = (wr_data == FIRE_SOFT_D);
    end else begin : g_nosoft
      assign soft_arm_ok  = 1'b0;
      assign soft_fire_ok = 1'b0;
    end
  endgenerate

  assign arm_hit   = at_arm && ((wr_data == ARM_HARD_D) || soft_arm_ok);
  assign arm_kind  = wr_data[SEL_BIT] ? KIND_HARD : KIND_SOFT;
  assign fire_hard = at_fire && (wr_data == FIRE_HARD_D);
  assign fire_soft = at_fire && soft_fire_ok;

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  input  logic active,
  output logic done
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cnt_q <= '0;
    else if (start)           cnt_q <= CNT_W'(PULSE_CYCLES - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done = (cnt_q == '0);

  // R7: the pulse counter steps down once per cycle while the pulse runs
  p_tick_r7: assert property (@(posedge clk) disable iff (!por_n)
    active && !start && !done |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic       arm_hit,
  input  rst_kind_e  arm_kind,
  input  logic       fire_hard,
  input  logic       fire_soft,
  input  logic       pulse_done,
  output seq_state_e state,
  output rst_kind_e  kind,
  output logic       pulse_start
);

  seq_state_e state_d;
  rst_kind_e  kind_d;
  logic       completes;

  assign completes   = (kind == KIND_HARD) ? fire_hard : fire_soft;
  assign pulse_start = (state == ST_ARMED) && completes;

  always_comb begin
    state_d = state;
    kind_d  = kind;
    unique case (state)
      ST_IDLE: if (arm_hit) begin
        state_d = ST_ARMED;
        kind_d  = arm_kind;
      end
      ST_ARMED: if (wr_en) state_d = completes ? ST_PULSE : ST_IDLE;
      ST_PULSE: if (pulse_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= ST_IDLE;
      kind  <= KIND_SOFT;
    end else begin
      state <= state_d;
      kind  <= kind_d;
    end
  end

  // R1: a qualifying first write arms
  p_arm_r1: assert property (@(posedge clk) disable iff (!por_n)
    state == ST_IDLE && arm_hit |=> state == ST_ARMED);
  // R2: the matching second write starts the pulse
  p_fire_r2: assert property (@(posedge clk) disable iff (!por_n)
    state == ST_ARMED && ((kind == KIND_HARD && fire_hard) || (kind == KIND_SOFT && fire_soft))
    |=> state == ST_PULSE);
  // R5: any other write while armed drops back to idle
  p_break_r5: assert property (@(posedge clk) disable iff (!por_n)
    state == ST_ARMED && wr_en && !fire_hard && !fire_soft |=> state == ST_IDLE);
  // R6: a fire write from idle never starts a pulse
  p_noorder_r6: assert property (@(posedge clk) disable iff (!por_n)
    state == ST_IDLE && (fire_hard || fire_soft) |=> state != ST_PULSE);
  // R8: writes during a running pulse neither end it nor change its kind
  p_ignore_r8: assert property (@(posedge clk) disable iff (!por_n)
    state == ST_PULSE && !pulse_done |=> state == ST_PULSE && $stable(kind));
  // R7: the pulse ends when the timer expires
  p_end_r7: assert property (@(posedge clk) disable iff (!por_n)
    state == ST_PULSE && pulse_done |=> state == ST_IDLE);

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          DATA_W       = 32,
  parameter logic [31:0] ARM_ADDR     = 32'hFFFF_FFF0,
  parameter logic [31:0] FIRE_ADDR    = 32'hFFFF_FFF4,
  parameter int          PULSE_CYCLES = 16,
  parameter bit          SOFT_EN      = 1'b1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cpu_rst,
  output logic              bus_rst_n,
  output logic              drv_rst,
  output logic              cpu_init
);

  logic       arm_hit, fire_hard, fire_soft;
  rst_kind_e  arm_kind, kind;
  seq_state_e state;
  logic       pulse_start, pulse_done, pulsing;

  rstseq_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARM_ADDR(ARM_ADDR),
    .FIRE_ADDR(FIRE_ADDR), .SOFT_EN(SOFT_EN)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arm_hit(arm_hit), .arm_kind(arm_kind),
    .fire_hard(fire_hard), .fire_soft(fire_soft)
  );

  rstseq_fsm u_fsm (
    .clk(clk), .por_n(por_n), .wr_en(wr_en),
    .arm_hit(arm_hit), .arm_kind(arm_kind),
    .fire_hard(fire_hard), .fire_soft(fire_soft),
    .pulse_done(pulse_done),
    .state(state), .kind(kind), .pulse_start(pulse_start)
  );

  rstseq_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk(clk), .por_n(por_n), .start(pulse_start),
    .active(pulsing), .done(pulse_done)
  );

  assign pulsing   = (state == ST_PULSE);
  assign cpu_rst   = pulsing && (kind == KIND_HARD);
  assign drv_rst   = pulsing && (kind == KIND_HARD);
  assign bus_rst_n = !(pulsing && (kind == KIND_HARD));
  assign cpu_init  = pulsing && (kind == KIND_SOFT);

  // R9: outputs are released on the first cycle after power-on reset
  p_por_quiet_r9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(por_n) |-> !cpu_rst && bus_rst_n && !drv_rst && !cpu_init);

endmodule

// File: tb/rstseq_top_tb_top.sv
`timescale 1ns/1ps
module rstseq_top_tb_top;

  localparam int P = 16;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cpu_rst, bus_rst_n, drv_rst, cpu_init;
  logic ns_cpu_rst, ns_bus_rst_n, ns_drv_rst, ns_cpu_init;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  rstseq_top #(.PULSE_CYCLES(P)) dut_i (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_rst(cpu_rst), .bus_rst_n(bus_rst_n), .drv_rst(drv_rst), .cpu_init(cpu_init)
  );

  rstseq_top #(.PULSE_CYCLES(P), .SOFT_EN(1'b0)) dut_nosoft_i (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_rst(ns_cpu_rst), .bus_rst_n(ns_bus_rst_n), .drv_rst(ns_drv_rst), .cpu_init(ns_cpu_init)
  );

  // Behavioural reference: 0 idle, 1 waiting for the fire write, 2 pulsing
  int m_mode = 0;
  int m_left = 0;
  bit m_hard = 0;

  always @(posedge clk) begin
    if (!por_n) begin
      m_mode = 0; m_left = 0;
    end else if (m_mode == 0) begin
      if (wr_en && wr_addr == 32'hFFFF_FFF0 && (wr_data == 32'd2 || wr_data == 32'd0)) begin
        m_mode = 1; m_hard = (wr_data == 32'd2);
      end
    end else if (m_mode == 1) begin
      if (wr_en) begin
        if (wr_addr == 32'hFFFF_FFF4 && wr_data == (m_hard ? 32'd6 : 32'd4)) begin
          m_mode = 2; m_left = P;
        end else m_mode = 0;
      end
    end else begin
      m_left = m_left - 1;
      if (m_left == 0) m_mode = 0;
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {cpu_rst,bus_rst_n,drv_rst,cpu_init} actual %b expected %b at cycle %0d",
               req, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the reference, away from the active edge
  int hard_cycles = 0;
  always @(negedge clk) begin
    logic [3:0] exp;
    string req;
    if (m_mode == 2 && m_hard)       begin exp = 4'b1010; req = "R3"; end
    else if (m_mode == 2)            begin exp = 4'b0101; req = "R4"; end
    else if (!por_n)                 begin exp = 4'b0100; req = "R9"; end
    else                             begin exp = 4'b0100; req = "R7"; end
    check(req, {cpu_rst, bus_rst_n, drv_rst, cpu_init}, exp);
    // R10: soft-less instance never drives INIT, and stays quiet during soft pulses
    if (m_mode == 2 && !m_hard)
      check("R10", {ns_cpu_rst, ns_bus_rst_n, ns_drv_rst, ns_cpu_init}, 4'b0100);
    else if (ns_cpu_init !== 1'b0)
      check("R10", {3'b000, ns_cpu_init}, 4'b0000);
    if (cpu_rst) hard_cycles++;
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R9: reset state
    idle(3);
    check("R9", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    por_n = 1'b1;
    idle(2);

    // R1, R2, R3, R7: back-to-back hard pair, count pulse length
    hard_cycles = 0;
    wr(32'hFFFF_FFF0, 32'd2);
    check("R1", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    wr(32'hFFFF_FFF4, 32'd6);
    check("R2", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b1010);
    idle(P + 3);
    check("R7", {4'(hard_cycles)}, 4'(P));

    // R4: soft pair with idle gap between the writes
    wr(32'hFFFF_FFF0, 32'd0);
    idle(3);
    wr(32'hFFFF_FFF4, 32'd4);
    check("R4", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0101);
    idle(P + 3);

    // R5: wrong fire data, then a lone correct fire write
    wr(32'hFFFF_FFF0, 32'd2);
    wr(32'hFFFF_FFF4, 32'd7);
    wr(32'hFFFF_FFF4, 32'd6);
    check("R5", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    idle(2);

    // R5: hard arm followed by soft fire code
    wr(32'hFFFF_FFF0, 32'd2);
    wr(32'hFFFF_FFF4, 32'd4);
    check("R5", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    idle(2);

    // R5: repeated arming write breaks, following fire does nothing
    wr(32'hFFFF_FFF0, 32'd2);
    wr(32'hFFFF_FFF0, 32'd2);
    wr(32'hFFFF_FFF4, 32'd6);
    check("R5", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    idle(2);

    // R5: write to an unrelated address breaks the pair
    wr(32'hFFFF_FFF0, 32'd0);
    wr(32'h0000_1000, 32'd4);
    wr(32'hFFFF_FFF4, 32'd4);
    check("R5", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    idle(2);

    // R6: reversed order, then a break to clear the arm it leaves
    wr(32'hFFFF_FFF4, 32'd6);
    check("R6", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    wr(32'hFFFF_FFF0, 32'd2);
    check("R6", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    wr(32'h0000_0000, 32'd0);
    idle(2);

    // R8: writes during a hard pulse neither change it nor leave an arm
    hard_cycles = 0;
    wr(32'hFFFF_FFF0, 32'd2);
    wr(32'hFFFF_FFF4, 32'd6);
    idle(3);
    wr(32'hFFFF_FFF0, 32'd0);
    wr(32'hFFFF_FFF4, 32'd4);
    check("R8", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b1010);
    wr(32'hFFFF_FFF0, 32'd2);
    idle(P + 2);
    check("R8", {4'(hard_cycles)}, 4'(P));
    wr(32'hFFFF_FFF4, 32'd4);
    wr(32'hFFFF_FFF4, 32'd6);
    check("R8", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    idle(2);

    // R9: power-on reset in the middle of a pulse ends it
    wr(32'hFFFF_FFF0, 32'd2);
    wr(32'hFFFF_FFF4, 32'd6);
    idle(4);
    por_n = 1'b0;
    idle(2);
    check("R9", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);
    por_n = 1'b1;
    idle(3);
    check("R9", {cpu_rst, bus_rst_n, drv_rst, cpu_init}, 4'b0100);

    // R10: soft pair on the soft-less instance
    wr(32'hFFFF_FFF0, 32'd0);
    wr(32'hFFFF_FFF4, 32'd4);
    check("R10", {ns_cpu_rst, ns_bus_rst_n, ns_drv_rst, ns_cpu_init}, 4'b0100);
    idle(P + 3);

    finish_run();
  end

endmodule